// File: doc/BRIEF.md
# Real-Time Clock Interrupt Status and Request Logic

This block keeps the interrupt status byte of a real-time clock. Three event sources feed it: a periodic tick, an alarm match and an update-complete notice. Each event arrives as a one-cycle pulse and is latched into its own flag. A flag is latched whether or not its source is enabled, so software can poll for it. The flags are ANDed with three enable inputs, and the results are ORed into an active-low request pin. A summary bit in the status byte mirrors that pin.

A host read is a two-pulse handshake. The start pulse opens the read and freezes the flags, so the byte the host sees cannot change under it. The end pulse clears every flag and the summary bit. In that same clock it loads the flags with any events that arrived while the read was open. A read therefore never loses an event, and never returns a flag that it then clears without the host having seen it.

Top module: `rtc_irq_status`

## Requirements
- R1: A synchronous active-high reset clears all flags. After reset the status byte is 0x00 and `irq_n_o` is high.
- R2: With no read open, a pulse on `event_i` sets the matching flag one clock later, whatever the enable bits are. The mapping is: `event_i[2]` (periodic) sets status bit 6, `event_i[1]` (alarm) sets bit 5, and `event_i[0]` (update-complete) sets bit 4. Status bits 3..0 always read 0.
- R3: `irq_n_o` is low exactly when some source has both its flag and its `enable_i` bit set. It follows a change of `enable_i` in the same cycle.
- R4: Status bit 7 is 1 exactly when `irq_n_o` is low.
- R5: From the clock after an accepted `rd_start_i` until the clock that takes `rd_end_i`, the flag bits do not change, even if events arrive.
- R6: An accepted `rd_end_i` clears every flag that was set, and clears status bit 7.
- R7: An event that arrives in any cycle from the accepted `rd_start_i` to the `rd_end_i` cycle, inclusive, is held back. Its flag appears one clock after `rd_end_i`.
- R8: `rd_end_i` has no effect when no read is open. `rd_start_i` has no effect while a read is open, and events then stay deferred. If both pulses arrive in the same cycle with no read open, the start is taken and the end is ignored.
- R9: Any combination of one, two or three flags can be set at once, and each one is reported independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| event_i | input | 3 | One-cycle event pulses: [2] periodic, [1] alarm, [0] update-complete |
| enable_i | input | 3 | Per-source request enables, same bit order as `event_i` |
| rd_start_i | input | 1 | Pulse that opens a host read and freezes the flags |
| rd_end_i | input | 1 | Pulse that closes the read, clears the flags and posts deferred events |
| status_o | output | 8 | Status byte: [7] request summary, [6:4] flags, [3:0] zero |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
The bench sweeps every pattern of preset flags against every pattern of deferred events. This exposes a design that clears a flag raised during the read, or that lets the status byte change while a read is open. Events are placed on the start cycle, a middle cycle and the end cycle, because a design that sampled the deferral window one cycle short would silently lose the events at its edges. The enable vector is walked over all eight values with the flags held. This catches a request pin that ignores an enable, or a summary bit that disagrees with the pin. Stray start and end pulses are also issued, to catch control logic that clears flags or reopens a read when it should not.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
   localparam int unsigned DEF_NUM_SRC  = 3;
   localparam int unsigned DEF_REG_W    = 8;
   localparam int unsigned DEF_FLAG_LSB = 4;
   localparam int unsigned DEF_SUM_BIT  = 7;

   typedef enum logic {
      RD_IDLE = 1'b0,
      RD_OPEN = 1'b1
   } rd_state_e;
endpackage

// File: rtl/rtc_irq_read_ctl.sv
module rtc_irq_read_ctl
   import rtc_irq_pkg::*;
(
   input  logic clk_i,
   input  logic rst_i,
   input  logic rd_start_i,
   input  logic rd_end_i,
   output logic open_o,
   output logic accept_o,
   output logic close_o
);
   rd_state_e state_q, state_d;

   always_comb begin
      state_d  = state_q;
      accept_o = 1'b0;
      close_o  = 1'b0;
      unique case (state_q)
         RD_IDLE: if (rd_start_i) begin
            accept_o = 1'b1;
            state_d  = RD_OPEN;
         end
         RD_OPEN: if (rd_end_i) begin
            close_o = 1'b1;
            state_d = RD_IDLE;
         end
         default: state_d = RD_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) state_q <= RD_IDLE;
      else       state_q <= state_d;
   end

   assign open_o = (state_q == RD_OPEN);

   AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (rst_i)
      (open_o && rd_start_i && !rd_end_i) |=> open_o);               // R8
   AST_END_IGNORED: assert property (@(posedge clk_i) disable iff (rst_i)
      (!open_o && rd_end_i) |=> open_o == $past(rd_start_i));        // R8
endmodule

// File: rtl/rtc_irq_flag_cell.sv
module rtc_irq_flag_cell (
   input  logic clk_i,
   input  logic rst_i,
   input  logic event_i,
   input  logic open_i,
   input  logic accept_i,
   input  logic close_i,
   output logic flag_o
);
   logic flag_q, hold_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         flag_q <= 1'b0;
         hold_q <= 1'b0;
      end else if (close_i) begin
         flag_q <= hold_q | event_i;
         hold_q <= 1'b0;
      end else if (open_i || accept_i) begin
         hold_q <= hold_q | event_i;
      end else begin
         flag_q <= flag_q | event_i;
      end
   end

   assign flag_o = flag_q;

   AST_FLAG_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
      (open_i && !close_i) |=> $stable(flag_o));                      // R5
   AST_CLEAR_ON_END: assert property (@(posedge clk_i) disable iff (rst_i)
      (close_i && !hold_q && !event_i) |=> !flag_o);                  // R6
   AST_DEFER_KEEP: assert property (@(posedge clk_i) disable iff (rst_i)
      (open_i && !close_i && event_i) |=> hold_q);                    // R7
   AST_POLL_SET: assert property (@(posedge clk_i) disable iff (rst_i)
      (!open_i && !accept_i && event_i) |=> flag_o);                  // R2
endmodule

// File: rtl/rtc_irq_req_merge.sv
module rtc_irq_req_merge #(
   parameter int unsigned NUM_SRC    = 3,
   parameter bit          ACTIVE_LOW = 1'b1
) (
   input  logic [NUM_SRC-1:0] flag_i,
   input  logic [NUM_SRC-1:0] enable_i,
   output logic               req_o,
   output logic               pin_o
);
   assign req_o = |(flag_i & enable_i);

   generate
      if (ACTIVE_LOW) begin : g_low
         assign pin_o = ~req_o;
      end else begin : g_high
         assign pin_o = req_o;
      end
   endgenerate
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
   import rtc_irq_pkg::*;
#(
   parameter int unsigned NUM_SRC    = DEF_NUM_SRC,
   parameter int unsigned REG_W      = DEF_REG_W,
   parameter int unsigned FLAG_LSB   = DEF_FLAG_LSB,
   parameter int unsigned SUM_BIT    = DEF_SUM_BIT,
   parameter bit          ACTIVE_LOW = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic [NUM_SRC-1:0] event_i,
   input  logic [NUM_SRC-1:0] enable_i,
   input  logic               rd_start_i,
   input  logic               rd_end_i,
   output logic [REG_W-1:0]   status_o,
   output logic               irq_n_o
);
   localparam int unsigned FLAG_MSB = FLAG_LSB + NUM_SRC - 1;

   if (NUM_SRC < 1) begin : g_chk_src
      $error("NUM_SRC must be at least 1");
   end
   if (FLAG_MSB >= SUM_BIT) begin : g_chk_pos
      $error("flag field overlaps summary bit");
   end
   if (SUM_BIT >= REG_W) begin : g_chk_w
      $error("summary bit outside register");
   end

   logic               rd_open, rd_accept, rd_close;
   logic [NUM_SRC-1:0] flags;
   logic               req;

   rtc_irq_read_ctl u_ctl (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .rd_start_i (rd_start_i),
      .rd_end_i   (rd_end_i),
      .open_o     (rd_open),
      .accept_o   (rd_accept),
      .close_o    (rd_close)
   );

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      rtc_irq_flag_cell u_cell (
         .clk_i    (clk_i),
         .rst_i    (rst_i),
         .event_i  (event_i[i]),
         .open_i   (rd_open),
         .accept_i (rd_accept),
         .close_i  (rd_close),
         .flag_o   (flags[i])
      );
   end

   rtc_irq_req_merge #(
      .NUM_SRC    (NUM_SRC),
      .ACTIVE_LOW (ACTIVE_LOW)
   ) u_merge (
      .flag_i   (flags),
      .enable_i (enable_i),
      .req_o    (req),
      .pin_o    (irq_n_o)
   );

   always_comb begin
      status_o                       = '0;
      status_o[FLAG_MSB:FLAG_LSB]    = flags;
      status_o[SUM_BIT]              = req;
   end

   AST_PIN_SUMMARY: assert property (@(posedge clk_i) disable iff (rst_i)
      status_o[SUM_BIT] == (irq_n_o != ACTIVE_LOW));                  // R4
   AST_REQ_ON_ENABLE: assert property (@(posedge clk_i) disable iff (rst_i)
      (|(status_o[FLAG_MSB:FLAG_LSB] & enable_i)) |-> (irq_n_o != ACTIVE_LOW)); // R3
   AST_LOW_BITS_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
      status_o[FLAG_LSB-1:0] == '0);                                  // R2
endmodule

// File: tb/sim_rtc_irq_status.sv
module sim_rtc_irq_status;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] ev = '0, en = '0;
   logic       st = 1'b0, fin = 1'b0;
   logic [7:0] stat;
   logic       irq_n;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   logic [2:0] mf = '0, mp = '0;
   bit         mo = 1'b0;

   always #2.5 clk = ~clk;

   rtc_irq_status u0 (
      .clk_i(clk), .rst_i(rst), .event_i(ev), .enable_i(en),
      .rd_start_i(st), .rd_end_i(fin), .status_o(stat), .irq_n_o(irq_n)
   );

   task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic expect_now(input string tag);
      logic       xirq_n;
      logic [7:0] xst;
      xirq_n = ~|(mf & en);
      xst    = {~xirq_n, mf, 4'b0000};
      chk(tag, {stat, irq_n}, {xst, xirq_n});
   endtask

   task automatic step(input logic [2:0] e, input logic s, input logic f,
                       input logic [2:0] n, input string tag);
      @(negedge clk);
      ev = e; st = s; fin = f; en = n;
      @(posedge clk);
      #1;
      if (!mo) begin
         if (s) begin mo = 1'b1; mp = e; end
         else mf = mf | e;
      end else begin
         if (f) begin mf = mp | e; mp = '0; mo = 1'b0; end
         else mp = mp | e;
      end
      ev = '0; st = 1'b0; fin = 1'b0;
      expect_now(tag);
   endtask

   task automatic clear_all();
      step(3'b000, 1'b1, 1'b0, en, "R6 open");
      step(3'b000, 1'b0, 1'b1, en, "R6 close");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      @(posedge clk); #1;
      chk("R1 reset", {stat, irq_n}, {8'h00, 1'b1});

      // R2 R3 R4 R9: every event pattern against every enable pattern
      for (int e = 1; e < 8; e++) begin
         clear_all();
         step(e[2:0], 1'b0, 1'b0, 3'b000, "R2 R9 flag set");
         for (int n = 0; n < 8; n++) begin
            step(3'b000, 1'b0, 1'b0, n[2:0], "R3 R4 enable sweep");
         end
      end

      // R5 R6 R7: preset flags against deferred events at three points
      for (int a = 0; a < 8; a++) begin
         for (int d = 0; d < 8; d++) begin
            for (int where = 0; where < 3; where++) begin
               clear_all();
               step(a[2:0], 1'b0, 1'b0, 3'b111, "R2 preset");
               step((where == 0) ? d[2:0] : 3'b000, 1'b1, 1'b0, 3'b111, "R5 start");
               step((where == 1) ? d[2:0] : 3'b000, 1'b0, 1'b0, 3'b111, "R5 frozen");
               step((where == 2) ? d[2:0] : 3'b000, 1'b0, 1'b1, 3'b111, "R6 R7 close");
               step(3'b000, 1'b0, 1'b0, 3'b111, "R7 posted");
            end
         end
      end

      // R8: stray pulses
      clear_all();
      step(3'b101, 1'b0, 1'b0, 3'b111, "R8 preset");
      step(3'b000, 1'b0, 1'b1, 3'b111, "R8 end ignored");
      step(3'b000, 1'b1, 1'b0, 3'b111, "R8 open");
      step(3'b010, 1'b1, 1'b0, 3'b111, "R8 start ignored");
      step(3'b000, 1'b0, 1'b1, 3'b111, "R8 close");
      step(3'b000, 1'b1, 1'b1, 3'b111, "R8 start wins");
      step(3'b001, 1'b0, 1'b0, 3'b111, "R8 still open");
      step(3'b000, 1'b0, 1'b1, 3'b111, "R8 final close");

      // R1: reset in the middle of activity
      step(3'b111, 1'b0, 1'b0, 3'b111, "R9 all set");
      @(negedge clk); rst = 1'b1;
      @(posedge clk); #1;
      mf = '0; mp = '0; mo = 1'b0;
      @(negedge clk); rst = 1'b0;
      @(posedge clk); #1;
      chk("R1 mid reset", {stat, irq_n}, {8'h00, 1'b1});

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule